// File: doc/BRIEF.md
# Quadratic Permutation Address Generator

This block produces the read-address sequence of a quadratic permutation interleaver. For a block of length K with coefficients f1 and f2, it emits address number i as (f1·i + f2·i²) mod K for i = 0 to K−1, one address per advance. It uses no multipliers and no stored index table. A second-order incremental recursion needs only modular adders, each an addition followed by a conditional subtraction of K.

The length and both coefficients are sampled on a start pulse and held for the whole frame. Address 0 appears, flagged valid, in the cycle after the start pulse. Each cycle in which the advance enable is high moves the output to the next address. The last flag marks index K−1. An advance on that final address ends the frame, and the block then stays idle until the next start. A buffer memory placed beside the block uses the addresses to read data in interleaved order.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is low, and after it is released with no start, `addr_vld` and `addr_last` are 0.
- R2: In the cycle after `start` is high, `addr_vld` is 1 and `addr` is 0.
- R3: Each cycle in which `adv` is high while `addr_vld` is 1 and `addr_last` is 0 (and `start` is low) moves `addr` from index i to index i+1, where the value for index i is (f1·i + f2·i²) mod K.
- R4: While `addr_vld` is 1 and both `adv` and `start` are low, `addr` holds its value.
- R5: `addr_last` is 1 exactly when `addr_vld` is 1 and the current index is K−1.
- R6: An advance while `addr_last` is 1 clears `addr_vld` in the next cycle. It then stays 0, whatever `adv` does, until the next `start`.
- R7: `blk_k`, `coef_a` and `coef_b` are sampled only at `start`. Changing them during a frame does not alter the addresses that follow.
- R8: A `start` during a frame restarts the sequence at index 0 with the newly sampled values.
- R9: Every valid address is below K, and the K addresses of a frame form a permutation of 0 to K−1 (K from 40 to 6144, with legal coefficients f1, f2 < K).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame and samples length and coefficients |
| adv | input | 1 | Step to the next address |
| blk_k | input | 13 | Block length K |
| coef_a | input | 13 | Linear coefficient f1 |
| coef_b | input | 13 | Quadratic coefficient f2 |
| addr | output | 13 | Current interleaved address |
| addr_vld | output | 1 | Address is valid |
| addr_last | output | 1 | Current address is index K−1 |

## Verification
The hardest case is an accumulated-modulus error late in a long frame. The recursion can drift only when both running sums cross K many times, so the stimulus runs the full 6144-address frame with large coefficients, as well as short frames. Every address is compared against the direct formula, and a seen-bitmap checks that the frame is a permutation. During each frame the coefficient and length ports are driven with unrelated values. Further directed steps stall the advance, restart a frame midway and hold the advance high after the frame ends.

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic [AW-1:0] blk_k,
  input  logic [AW-1:0] coef_a,
  input  logic [AW-1:0] coef_b,
  output logic [AW-1:0] addr,
  output logic          addr_vld,
  output logic          addr_last
);

  function automatic logic [AW-1:0] mod_add(input logic [AW-1:0] a,
                                            input logic [AW-1:0] b,
                                            input logic [AW-1:0] m);
    logic [AW:0] s;
    logic [AW:0] d;
    s = {1'b0, a} + {1'b0, b};
    d = s - {1'b0, m};
    return (s >= {1'b0, m}) ? d[AW-1:0] : s[AW-1:0];
  endfunction

  logic [AW-1:0] k_q;
  logic [AW-1:0] incr_q;
  logic [AW-1:0] step_q;
  logic [AW-1:0] idx_q;

  assign addr_last = addr_vld && (idx_q == k_q - AW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q      <= '0;
      incr_q   <= '0;
      step_q   <= '0;
      idx_q    <= '0;
      addr     <= '0;
      addr_vld <= 1'b0;
    end else if (start) begin
      k_q      <= blk_k;
      incr_q   <= mod_add(coef_a, coef_b, blk_k);
      step_q   <= mod_add(coef_b, coef_b, blk_k);
      idx_q    <= '0;
      addr     <= '0;
      addr_vld <= 1'b1;
    end else if (adv && addr_vld) begin
      if (addr_last) begin
        addr_vld <= 1'b0;
      end else begin
        addr   <= mod_add(addr, incr_q, k_q);
        incr_q <= mod_add(incr_q, step_q, k_q);
        idx_q  <= idx_q + AW'(1);
      end
    end
  end

endmodule

module qpp_addr_gen_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          adv,
  input logic [AW-1:0] addr,
  input logic          addr_vld,
  input logic          addr_last,
  input logic [AW-1:0] k_q
);

  // R2
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr_vld && addr == '0));

  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !adv && !start) |=> $stable(addr));

  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_last |-> addr_vld);

  // R6
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && adv && !start) |=> !addr_vld);

  // R6
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_vld && !start) |=> !addr_vld);

  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> (addr < k_q));

endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .addr(addr),
  .addr_vld(addr_vld), .addr_last(addr_last), .k_q(k_q)
);

// File: tb/qpp_addr_gen_test.sv
module qpp_addr_gen_test;
  localparam int AW = 13;
  localparam int NV = 4;
  localparam int VK [NV] = '{40, 6144, 48, 1024};
  localparam int VA [NV] = '{3, 263, 7, 31};
  localparam int VB [NV] = '{10, 480, 12, 64};

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic adv = 0;
  logic [AW-1:0] blk_k = '0, coef_a = '0, coef_b = '0;
  logic [AW-1:0] addr;
  logic addr_vld, addr_last;

  int n_chk = 0;
  int n_bad = 0;
  bit seen [6144];

  always #5 clk = ~clk;

  qpp_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .blk_k(blk_k),
    .coef_a(coef_a), .coef_b(coef_b), .addr(addr), .addr_vld(addr_vld),
    .addr_last(addr_last)
  );

  function automatic int qpp(int k, int a, int b, int i);
    longint v;
    v = (longint'(a) * i + longint'(b) * i * i) % k;
    return int'(v);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_frame(int k, int a, int b);
    @(negedge clk);
    blk_k = AW'(k); coef_a = AW'(a); coef_b = AW'(b); start = 1;
    @(negedge clk);
    start = 0;
    // R7: scramble the ports for the rest of the frame
    blk_k = AW'(17); coef_a = AW'(5); coef_b = AW'(9);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 vld in reset", addr_vld, 0);
    check("R1 last in reset", addr_last, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 vld idle", addr_vld, 0);

    for (int v = 0; v < NV; v++) begin
      int k;
      int ok;
      int perm;
      k = VK[v]; ok = 1; perm = 1;
      for (int j = 0; j < 6144; j++) seen[j] = 0;
      begin_frame(k, VA[v], VB[v]);
      check("R2 first vld", addr_vld, 1);
      check("R2 first addr", addr, 0);
      adv = 1;
      for (int i = 0; i < k; i++) begin
        if (addr != AW'(qpp(k, VA[v], VB[v], i)) || !addr_vld) begin
          ok = 0;
          check("R3 R7 addr", addr, qpp(k, VA[v], VB[v], i));
        end
        if (addr_last != (i == k - 1)) begin
          ok = 0;
          check("R5 last", addr_last, i == k - 1);
        end
        if (addr < k) begin
          if (seen[addr]) perm = 0;
          seen[addr] = 1;
        end else perm = 0;
        @(negedge clk);
      end
      check("R3 whole sequence", ok, 1);
      check("R9 permutation", perm, 1);
      check("R6 vld after last", addr_vld, 0);
      repeat (3) @(negedge clk);
      check("R6 stays idle", addr_vld, 0);
      adv = 0;
    end

    // R4 stall and R8 restart
    begin_frame(40, 3, 10);
    adv = 1;
    repeat (5) @(negedge clk);
    adv = 0;
    check("R3 index 5", addr, qpp(40, 3, 10, 5));
    repeat (3) @(negedge clk);
    check("R4 held", addr, qpp(40, 3, 10, 5));
    check("R4 vld held", addr_vld, 1);
    adv = 1;
    @(negedge clk);
    check("R4 resumes", addr, qpp(40, 3, 10, 6));
    adv = 0;
    begin_frame(48, 7, 12);
    check("R8 restart addr", addr, 0);
    adv = 1;
    @(negedge clk);
    check("R8 new coefs", addr, qpp(48, 7, 12, 1));
    @(negedge clk);
    check("R8 index 2", addr, qpp(48, 7, 12, 2));
    adv = 0;

    rst_n = 0;
    @(negedge clk);
    check("R1 reset clears", addr_vld, 0);
    summary();
  end
endmodule